// File: doc/BRIEF.md
# Threshold-Interrupt Byte FIFO

This block is a sixteen-byte buffer that sits between a host register interface and a peripheral data port. A direction bit selects which side fills it. In peripheral-to-host mode the peripheral pushes bytes and the host reads them. In host-to-peripheral mode the host writes bytes and the peripheral drains them. The host sees full, empty, the byte count, the threshold, the direction, a service flag and a sticky error bit. On the host side, bytes move through single-cycle read and write strobes. On the peripheral side, bytes move through valid/ready streams.

The block raises a one-cycle service interrupt when a programmable 4-bit threshold says a burst is worthwhile. In peripheral-to-host mode this is when enough bytes are waiting. In host-to-peripheral mode it is when enough space is free. While the service flag is 1, the interrupt is held off. The flag sets itself when the interrupt fires, and the host re-arms it by writing 0. If the condition still holds at that point, the interrupt fires again. This repeats until the transfer is done.

Back-pressure on the peripheral streams:
- A byte moves only in a cycle where both valid and ready are high.
- `periph_in_ready` is low when the buffer is full, in host-to-peripheral mode, or in a cycle that flushes.
- `periph_out_valid` is low when the buffer is empty, in peripheral-to-host mode, or in a cycle that flushes.
- `periph_out_data` holds the head byte and stays stable until it is taken.

Top module: `thresh_irq_fifo`

## Requirements
- R1: After reset the count is 0, `sts_empty`=1, `sts_full`=0, `sts_svc`=0, `sts_err`=0, `sts_thr`=0, `sts_dir`=0 (peripheral-to-host) and `irq`=0.
- R2: The buffer holds up to 16 bytes and returns them in the order written. `sts_count` gives the occupancy from 0 to 16, and `sts_full` is 1 exactly at 16.
- R3: In host-to-peripheral mode, a host write while full is dropped: the count and contents are unchanged, and `sts_err` becomes 1.
- R4: In peripheral-to-host mode, a host read while empty is dropped and `sts_err` becomes 1. `sts_err` stays 1 until a `cfg_err_clr` pulse clears it.
- R5: With `sts_dir`=0, the interrupt condition is count >= 16 - threshold. For example, threshold 12 fires at 4 bytes, and threshold 0 fires only at 16.
- R6: With `sts_dir`=1, the interrupt condition is count <= threshold. For example, threshold 12 fires at 12 bytes or fewer and not at 13.
- R7: `irq` is high only while `sts_svc`=0 and the condition holds. The cycle after `irq` is high, `sts_svc` reads 1 and `irq` drops. A host write of 0 to `sts_svc` (`cfg_svc_wr` with `cfg_svc`=0) re-arms it, and `irq` fires again if the condition still holds.
- R8: Writing a direction value different from the current one empties the buffer, so the count reads 0 on the next cycle.
- R9: A strobe for the inactive direction is ignored and sets no error: a host write while `sts_dir`=0, or a host read while `sts_dir`=1.
- R10: `periph_in_ready` is 1 only with `sts_dir`=0 and the buffer not full. `periph_out_valid` is 1 only with `sts_dir`=1 and the buffer not empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host byte write strobe |
| host_wdata | input | 8 | Host write byte |
| host_rd | input | 1 | Host byte read strobe (pops the head) |
| host_rdata | output | 8 | Head byte for the host |
| cfg_thr_wr | input | 1 | Threshold write strobe |
| cfg_thr | input | 4 | New threshold |
| cfg_dir_wr | input | 1 | Direction write strobe |
| cfg_dir | input | 1 | New direction: 0 peripheral-to-host, 1 host-to-peripheral |
| cfg_svc_wr | input | 1 | Service flag write strobe |
| cfg_svc | input | 1 | New service flag value |
| cfg_err_clr | input | 1 | Clears the sticky error |
| sts_thr | output | 4 | Current threshold |
| sts_dir | output | 1 | Current direction |
| sts_svc | output | 1 | Service flag |
| sts_full | output | 1 | Buffer full |
| sts_empty | output | 1 | Buffer empty |
| sts_count | output | 5 | Occupancy, 0 to 16 |
| sts_err | output | 1 | Sticky overflow/underflow error |
| irq | output | 1 | Service interrupt, one cycle per firing |
| periph_in_valid | input | 1 | Peripheral byte offered |
| periph_in_ready | output | 1 | Buffer accepts the peripheral byte |
| periph_in_data | input | 8 | Peripheral byte in |
| periph_out_valid | output | 1 | Head byte offered to the peripheral |
| periph_out_ready | input | 1 | Peripheral takes the head byte |
| periph_out_data | output | 8 | Head byte for the peripheral |

## Verification
Four properties are checked on every cycle:
- the count stays within 0 to 16, and no push reaches a full store and no pop reaches an empty one;
- the error bit holds until it is cleared;
- a firing interrupt sets the service flag and does not repeat in the next cycle unless the host writes the flag;
- a direction flip empties the buffer.

Only the bench scenarios can show the rest: the threshold boundaries in each direction (one byte below and at the trip point), byte ordering through both paths, re-firing after the host re-arms, and the silence of strobes for the inactive direction.

// File: rtl/tif_pkg.sv
`timescale 1ns/1ps
package tif_pkg;
  typedef enum logic {
    DIR_P2H = 1'b0,
    DIR_H2P = 1'b1
  } dir_e;
endpackage

// File: rtl/tif_store.sv
`timescale 1ns/1ps
module tif_store #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned DW    = 8,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic          pop,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);
  localparam logic [AW-1:0] LAST_P  = AW'(DEPTH - 1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == LAST_P) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      unique case ({push, pop})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

  assign rdata = mem[rd_ptr];
  assign full  = (count == DEPTH_C);
  assign empty = (count == '0);

  // R2: occupancy never leaves 0..DEPTH
  p_count_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    count <= DEPTH_C);
  // R3: control never pushes into a full store
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !push);
  // R4: control never pops an empty store
  p_no_underflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> !pop);
endmodule

// File: rtl/tif_ctrl.sv
`timescale 1ns/1ps
module tif_ctrl
  import tif_pkg::*;
#(
  parameter int unsigned TW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_wr,
  input  logic          host_rd,
  input  logic          thr_wr,
  input  logic [TW-1:0] thr_wdata,
  input  logic          dir_wr,
  input  logic          dir_wdata,
  input  logic          err_clr,
  input  logic          full,
  input  logic          empty,
  input  logic          in_valid,
  input  logic          out_ready,
  output logic [TW-1:0] thr_q,
  output dir_e          dir_q,
  output logic          flush,
  output logic          push,
  output logic          pop,
  output logic          push_from_host,
  output logic          in_ready,
  output logic          out_valid,
  output logic          err_q
);
  logic err_set;

  always_comb begin
    flush     = dir_wr && (dir_e'(dir_wdata) != dir_q);
    in_ready  = (dir_q == DIR_P2H) && !full && !flush;
    out_valid = (dir_q == DIR_H2P) && !empty && !flush;
    if (dir_q == DIR_H2P) begin
      push           = host_wr && !full && !flush;
      pop            = out_valid && out_ready;
      push_from_host = 1'b1;
      err_set        = host_wr && full;
    end else begin
      push           = in_valid && in_ready;
      pop            = host_rd && !empty && !flush;
      push_from_host = 1'b0;
      err_set        = host_rd && empty;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      thr_q <= '0;
      dir_q <= DIR_P2H;
      err_q <= 1'b0;
    end else begin
      if (thr_wr) thr_q <= thr_wdata;
      if (dir_wr) dir_q <= dir_e'(dir_wdata);
      err_q <= err_set | (err_q & ~err_clr);
    end
  end

  // R4: error bit holds until cleared
  p_err_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && !err_clr) |=> err_q);
endmodule

// File: rtl/tif_irq.sv
`timescale 1ns/1ps
module tif_irq
  import tif_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned TW    = 4,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] count,
  input  logic [TW-1:0] thr,
  input  dir_e          dir,
  input  logic          svc_wr,
  input  logic          svc_wdata,
  output logic          irq,
  output logic          svc_q
);
  localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

  logic [CW-1:0] fill_need;
  logic          cond;

  always_comb begin
    fill_need = DEPTH_C - CW'(thr);
    if (dir == DIR_P2H) cond = (count >= fill_need);
    else                cond = (count <= CW'(thr));
    irq = cond && !svc_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      svc_q <= 1'b0;
    else if (svc_wr) svc_q <= svc_wdata;
    else if (irq)    svc_q <= 1'b1;
  end

  // R7: a firing interrupt sets the service flag
  p_svc_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !svc_wr) |=> svc_q);
  // R7: without a host re-arm the interrupt lasts one cycle
  p_irq_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !svc_wr) |=> !irq);
endmodule

// File: rtl/thresh_irq_fifo.sv
`timescale 1ns/1ps
module thresh_irq_fifo
  import tif_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned DW    = 8,
  localparam int unsigned TW   = $clog2(DEPTH),
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_wr,
  input  logic [DW-1:0] host_wdata,
  input  logic          host_rd,
  output logic [DW-1:0] host_rdata,
  input  logic          cfg_thr_wr,
  input  logic [TW-1:0] cfg_thr,
  input  logic          cfg_dir_wr,
  input  logic          cfg_dir,
  input  logic          cfg_svc_wr,
  input  logic          cfg_svc,
  input  logic          cfg_err_clr,
  output logic [TW-1:0] sts_thr,
  output logic          sts_dir,
  output logic          sts_svc,
  output logic          sts_full,
  output logic          sts_empty,
  output logic [CW-1:0] sts_count,
  output logic          sts_err,
  output logic          irq,
  input  logic          periph_in_valid,
  output logic          periph_in_ready,
  input  logic [DW-1:0] periph_in_data,
  output logic          periph_out_valid,
  input  logic          periph_out_ready,
  output logic [DW-1:0] periph_out_data
);
  dir_e          dir_q;
  logic          flush, push, pop, push_from_host;
  logic [DW-1:0] wdata, head;

  tif_ctrl #(.TW(TW)) ctrl_i (
    .clk(clk), .rst_n(rst_n),
    .host_wr(host_wr), .host_rd(host_rd),
    .thr_wr(cfg_thr_wr), .thr_wdata(cfg_thr),
    .dir_wr(cfg_dir_wr), .dir_wdata(cfg_dir),
    .err_clr(cfg_err_clr),
    .full(sts_full), .empty(sts_empty),
    .in_valid(periph_in_valid), .out_ready(periph_out_ready),
    .thr_q(sts_thr), .dir_q(dir_q),
    .flush(flush), .push(push), .pop(pop),
    .push_from_host(push_from_host),
    .in_ready(periph_in_ready), .out_valid(periph_out_valid),
    .err_q(sts_err)
  );

  assign wdata = push_from_host ? host_wdata : periph_in_data;

  tif_store #(.DEPTH(DEPTH), .DW(DW)) store_i (
    .clk(clk), .rst_n(rst_n),
    .flush(flush), .push(push), .pop(pop),
    .wdata(wdata), .rdata(head),
    .count(sts_count), .full(sts_full), .empty(sts_empty)
  );

  tif_irq #(.DEPTH(DEPTH), .TW(TW)) irq_i (
    .clk(clk), .rst_n(rst_n),
    .count(sts_count), .thr(sts_thr), .dir(dir_q),
    .svc_wr(cfg_svc_wr), .svc_wdata(cfg_svc),
    .irq(irq), .svc_q(sts_svc)
  );

  assign sts_dir         = dir_q;
  assign host_rdata      = head;
  assign periph_out_data = head;

  // R8: a direction flip leaves the store empty
  p_flush_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (sts_count == '0));
endmodule

// File: tb/thresh_irq_fifo_tb_top.sv
`timescale 1ns/1ps
module thresh_irq_fifo_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       host_wr = 0, host_rd = 0;
  logic [7:0] host_wdata = 0;
  logic [7:0] host_rdata;
  logic       cfg_thr_wr = 0, cfg_dir_wr = 0, cfg_dir = 0;
  logic       cfg_svc_wr = 0, cfg_svc = 0, cfg_err_clr = 0;
  logic [3:0] cfg_thr = 0;
  logic [3:0] sts_thr;
  logic       sts_dir, sts_svc, sts_full, sts_empty, sts_err, irq;
  logic [4:0] sts_count;
  logic       periph_in_valid = 0, periph_in_ready;
  logic [7:0] periph_in_data = 0;
  logic       periph_out_valid, periph_out_ready = 0;
  logic [7:0] periph_out_data;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  logic [7:0] exp_q[$];

  always #2 clk = ~clk;

  thresh_irq_fifo dut_i (
    .clk(clk), .rst_n(rst_n),
    .host_wr(host_wr), .host_wdata(host_wdata),
    .host_rd(host_rd), .host_rdata(host_rdata),
    .cfg_thr_wr(cfg_thr_wr), .cfg_thr(cfg_thr),
    .cfg_dir_wr(cfg_dir_wr), .cfg_dir(cfg_dir),
    .cfg_svc_wr(cfg_svc_wr), .cfg_svc(cfg_svc),
    .cfg_err_clr(cfg_err_clr),
    .sts_thr(sts_thr), .sts_dir(sts_dir), .sts_svc(sts_svc),
    .sts_full(sts_full), .sts_empty(sts_empty), .sts_count(sts_count),
    .sts_err(sts_err), .irq(irq),
    .periph_in_valid(periph_in_valid), .periph_in_ready(periph_in_ready),
    .periph_in_data(periph_in_data),
    .periph_out_valid(periph_out_valid), .periph_out_ready(periph_out_ready),
    .periph_out_data(periph_out_data)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // monitor: peripheral-side pops compared against the scoreboard
  always @(negedge clk) begin
    if (rst_n && periph_out_valid && periph_out_ready) begin
      if (exp_q.size() == 0) chk("R2 out with empty scoreboard", 1, 0);
      else chk("R2 periph_out_data order", periph_out_data, exp_q.pop_front());
    end
  end

  task automatic periph_push(input logic [7:0] d);
    periph_in_valid = 1; periph_in_data = d;
    exp_q.push_back(d);
    @(posedge clk); #1;
    periph_in_valid = 0;
  endtask

  task automatic host_write(input logic [7:0] d, input bit expect_take);
    host_wr = 1; host_wdata = d;
    if (expect_take) exp_q.push_back(d);
    @(posedge clk); #1;
    host_wr = 0;
  endtask

  task automatic host_read(input bit cmp);
    @(negedge clk);
    if (cmp) begin
      if (exp_q.size() == 0) chk("R2 read with empty scoreboard", 1, 0);
      else chk("R2 host_rdata order", host_rdata, exp_q.pop_front());
    end
    host_rd = 1;
    @(posedge clk); #1;
    host_rd = 0;
  endtask

  task automatic pulse_cfg(input int which, input logic [3:0] v);
    case (which)
      0: begin cfg_thr_wr = 1; cfg_thr = v; end
      1: begin cfg_dir_wr = 1; cfg_dir = v[0]; end
      2: begin cfg_svc_wr = 1; cfg_svc = v[0]; end
      default: cfg_err_clr = 1;
    endcase
    @(posedge clk); #1;
    cfg_thr_wr = 0; cfg_dir_wr = 0; cfg_svc_wr = 0; cfg_err_clr = 0;
  endtask

  task automatic drain_periph();
    periph_out_ready = 1;
    for (int i = 0; i < 20 && !sts_empty; i++) @(posedge clk);
    #1 periph_out_ready = 0;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      chk("watchdog expired", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 count", sts_count, 0);
    chk("R1 empty", sts_empty, 1);
    chk("R1 full", sts_full, 0);
    chk("R1 svc", sts_svc, 0);
    chk("R1 err", sts_err, 0);
    chk("R1 thr", sts_thr, 0);
    chk("R1 dir", sts_dir, 0);
    chk("R1 irq", irq, 0);
    @(posedge clk); #1;

    // R5 threshold 12, peripheral-to-host: fires at 4 bytes
    pulse_cfg(0, 4'd12);
    for (int i = 0; i < 3; i++) periph_push(8'hA0 + 8'(i));
    @(negedge clk);
    chk("R5 no irq at 3 bytes", irq, 0);
    @(posedge clk); #1;
    periph_push(8'hA3);
    @(negedge clk);
    chk("R5 irq at 4 bytes thr12", irq, 1);
    @(negedge clk);
    chk("R7 irq drops after firing", irq, 0);
    chk("R7 svc set by firing", sts_svc, 1);
    @(posedge clk); #1;

    // R2/R10 fill to 16
    for (int i = 4; i < 16; i++) periph_push(8'hA0 + 8'(i));
    @(negedge clk);
    chk("R2 full at 16", sts_full, 1);
    chk("R2 count 16", sts_count, 16);
    chk("R10 in_ready low when full", periph_in_ready, 0);
    @(posedge clk); #1;

    // R2 host reads all 16 in order
    for (int i = 0; i < 16; i++) host_read(1);
    @(negedge clk);
    chk("R2 empty after reads", sts_empty, 1);
    @(posedge clk); #1;

    // R4 read when empty
    host_read(0);
    @(negedge clk);
    chk("R4 err on empty read", sts_err, 1);
    chk("R4 count stays 0", sts_count, 0);
    @(negedge clk);
    chk("R4 err sticky", sts_err, 1);
    @(posedge clk); #1;
    pulse_cfg(3, 4'd0);
    @(negedge clk);
    chk("R4 err cleared", sts_err, 0);
    @(posedge clk); #1;

    // R9 host write in peripheral-to-host mode ignored
    host_write(8'h55, 0);
    @(negedge clk);
    chk("R9 host write ignored count", sts_count, 0);
    chk("R9 host write no err", sts_err, 0);
    @(posedge clk); #1;

    // R7 re-arm with condition false: no irq
    pulse_cfg(2, 4'd0);
    @(negedge clk);
    chk("R7 svc cleared", sts_svc, 0);
    chk("R5 no irq at 0 bytes thr12", irq, 0);
    @(posedge clk); #1;

    // R5 threshold 0: fires only at 16
    pulse_cfg(0, 4'd0);
    for (int i = 0; i < 15; i++) periph_push(8'hC0 + 8'(i));
    @(negedge clk);
    chk("R5 no irq at 15 thr0", irq, 0);
    @(posedge clk); #1;
    periph_push(8'hCF);
    @(negedge clk);
    chk("R5 irq at 16 thr0", irq, 1);
    @(posedge clk); #1;

    // R8 flip direction flushes 16 bytes
    pulse_cfg(1, 4'd1);
    exp_q.delete();
    @(negedge clk);
    chk("R8 count 0 after flip", sts_count, 0);
    chk("R8 dir now 1", sts_dir, 1);
    chk("R10 in_ready low in h2p", periph_in_ready, 0);
    chk("R10 out_valid low when empty", periph_out_valid, 0);
    chk("R7 irq held by svc", irq, 0);
    @(posedge clk); #1;

    // R6/R7 re-arm: count 0 <= thr 0 fires
    pulse_cfg(2, 4'd0);
    @(negedge clk);
    chk("R6 irq at 0 bytes thr0", irq, 1);
    @(negedge clk);
    chk("R7 svc set again", sts_svc, 1);
    @(posedge clk); #1;

    // R6 threshold 12: 13 bytes no irq, 12 bytes irq
    pulse_cfg(0, 4'd12);
    for (int i = 0; i < 13; i++) host_write(8'h10 + 8'(i), 1);
    pulse_cfg(2, 4'd0);
    @(negedge clk);
    chk("R6 no irq at 13 thr12", irq, 0);
    chk("R10 out_valid when data", periph_out_valid, 1);
    @(posedge clk); #1;
    periph_out_ready = 1;
    @(posedge clk); #1;
    periph_out_ready = 0;
    @(negedge clk);
    chk("R6 irq at 12 thr12", irq, 1);
    @(posedge clk); #1;

    // R3 overflow
    for (int i = 0; i < 4; i++) host_write(8'h40 + 8'(i), 1);
    @(negedge clk);
    chk("R2 full in h2p", sts_full, 1);
    @(posedge clk); #1;
    host_write(8'hEE, 0);
    @(negedge clk);
    chk("R3 err on full write", sts_err, 1);
    chk("R3 count stays 16", sts_count, 16);
    @(posedge clk); #1;

    // R2 peripheral drains in order (monitor compares)
    drain_periph();
    @(negedge clk);
    chk("R2 drained empty", sts_empty, 1);
    chk("R2 scoreboard drained", exp_q.size(), 0);
    @(posedge clk); #1;

    // R9 host read in h2p ignored, no error
    pulse_cfg(3, 4'd0);
    host_read(0);
    @(negedge clk);
    chk("R9 host read ignored no err", sts_err, 0);
    chk("R9 count stays 0", sts_count, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule